// File: doc/BRIEF.md
# Associative Tag Lookup with Companion Data Store

This block holds a small table of keys, each paired with a value. Software or a control path loads an entry by address. The key goes into a tag array and the value goes into a data store at the same index. Either part can be read back by address, as with an ordinary register file.

The main operation is a search. A key is compared with every valid stored tag in the same cycle. The compare produces one match line per entry and a miss flag. The match lines serve directly as the word selects of the data store, so one search returns the associated value. This is the translation pattern: a virtual key goes in and a physical value comes out.

If duplicate tags were loaded, the entry with the lowest index supplies the value and a multiple-hit flag is raised. All search and read results are registered. They appear one clock after the request.

Top module: `cam_lookup`

## Requirements
- R1: After reset every entry is invalid, and all registered outputs (match, miss, multi_hit, lookup_data, result_valid, rd_valid, rd_key, rd_data) are zero.
- R2: With wr_en high, the entry at addr takes wr_key as its tag and wr_data as its value and becomes valid. With rd_en high, rd_key and rd_data show that entry's tag and value one cycle later, and rd_valid pulses in that cycle.
- R3: With search_en high, result_valid is high in the next cycle, and bit i of match is 1 exactly when entry i is valid and its tag equals search_key. result_valid is low in any cycle that does not follow a search request.
- R4: miss is high in a result cycle exactly when match is all zeros, and lookup_data is then zero.
- R5: With a single matching entry, lookup_data equals the value stored at that entry's index.
- R6: When two or more entries match, multi_hit is high and lookup_data is the value of the matching entry with the lowest index. Otherwise multi_hit is low.
- R7: A write in the same cycle as a search does not affect that search. The search sees the table as it was before the write.
- R8: An entry that was never written does not match, even when search_key equals its zero reset contents.
- R9: A read and a write to the same address in the same cycle return the old tag and value. The new contents are returned by a later read.
- R10: match, miss, multi_hit and lookup_data hold their last search result through cycles with no search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load the entry at addr |
| addr | input | ADDR_W | Entry index for both load and read |
| wr_key | input | KEY_W | Tag to store |
| wr_data | input | DATA_W | Value to store |
| rd_en | input | 1 | Read the entry at addr |
| search_en | input | 1 | Start a search |
| search_key | input | KEY_W | Key to compare with all tags |
| rd_valid | output | 1 | Read result present this cycle |
| rd_key | output | KEY_W | Tag read by address |
| rd_data | output | DATA_W | Value read by address |
| result_valid | output | 1 | Search result present this cycle |
| match | output | ENTRIES | One line per entry, high on equality |
| miss | output | 1 | No entry matched |
| multi_hit | output | 1 | More than one entry matched |
| lookup_data | output | DATA_W | Value selected by the lowest match |

## Verification
Searches are issued against four kinds of table state:
- An empty table, with the key set to zero. This separates a valid-bit check from a raw tag compare.
- Distinct tags, probed with keys present at different indices and with absent keys. This shows whether the match lines and the selected value track the correct entry.
- A table in which a duplicate was loaded at a higher index. This exposes the wrong priority direction and a missing multi-hit flag.
- A table written in the same cycle as the search. Together with a same-cycle read and write, this tells old-contents behaviour from write-through behaviour.

Idle cycles between searches check that results are held.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_ONE   = 2'd1,
        HIT_MULTI = 2'd2
    } hit_kind_e;

endpackage

// File: rtl/cam_tag_array.sv
module cam_tag_array #(
    parameter int ENTRIES = 4,
    parameter int KEY_W   = 4,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [KEY_W-1:0]   wr_key,
    input  logic [KEY_W-1:0]   search_key,
    output logic [KEY_W-1:0]   rd_key,
    output logic [ENTRIES-1:0] match_raw
);

    typedef struct packed {
        logic [ENTRIES-1:0][KEY_W-1:0] tag;
        logic [ENTRIES-1:0]            vld;
    } tag_state_t;

    tag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tag[addr] = wr_key;
            st_d.vld[addr] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_key = st_q.tag[addr];

    // One comparator per entry; an invalid entry is masked off its line.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_raw[g] = st_q.vld[g] && (st_q.tag[g] == search_key);
    end

endmodule

// File: rtl/cam_prio_sel.sv
module cam_prio_sel
    import cam_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic [ENTRIES-1:0] match_raw,
    output logic [ENTRIES-1:0] word_sel,
    output hit_kind_e          hit_kind
);

    logic taken;

    always_comb begin
        word_sel = '0;
        taken    = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_raw[i] && !taken) begin
                word_sel[i] = 1'b1;
                taken       = 1'b1;
            end
        end
    end

    always_comb begin
        if (match_raw == '0)
            hit_kind = HIT_NONE;
        else if ((match_raw & (match_raw - ENTRIES'(1))) != '0)
            hit_kind = HIT_MULTI;
        else
            hit_kind = HIT_ONE;
    end

endmodule

// File: rtl/cam_data_ram.sv
module cam_data_ram #(
    parameter int ENTRIES = 4,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ENTRIES-1:0] word_sel,
    output logic [DATA_W-1:0]  rd_data,
    output logic [DATA_W-1:0]  sel_data
);

    logic [ENTRIES-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[addr];

    // Word selects drive an AND-OR read; all-zero selects give zero.
    always_comb begin
        sel_data = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel_data = sel_data | (mem_q[i] & {DATA_W{word_sel[i]}});
        end
    end

endmodule

// File: rtl/cam_lookup.sv
module cam_lookup
    import cam_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int KEY_W   = 4,
    parameter int DATA_W  = 8,
    localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [KEY_W-1:0]   wr_key,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic               search_en,
    input  logic [KEY_W-1:0]   search_key,
    output logic               rd_valid,
    output logic [KEY_W-1:0]   rd_key,
    output logic [DATA_W-1:0]  rd_data,
    output logic               result_valid,
    output logic [ENTRIES-1:0] match,
    output logic               miss,
    output logic               multi_hit,
    output logic [DATA_W-1:0]  lookup_data
);

    typedef struct packed {
        logic               rd_vld;
        logic [KEY_W-1:0]   rd_key;
        logic [DATA_W-1:0]  rd_data;
        logic               res_vld;
        logic [ENTRIES-1:0] match;
        logic               miss;
        logic               multi;
        logic [DATA_W-1:0]  lookup;
    } out_state_t;

    out_state_t o_d, o_q;

    logic [KEY_W-1:0]   tag_rd;
    logic [DATA_W-1:0]  val_rd;
    logic [DATA_W-1:0]  val_sel;
    logic [ENTRIES-1:0] match_raw;
    logic [ENTRIES-1:0] word_sel;
    hit_kind_e          hit_kind;

    cam_tag_array #(
        .ENTRIES(ENTRIES), .KEY_W(KEY_W), .ADDR_W(ADDR_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_key     (wr_key),
        .search_key (search_key),
        .rd_key     (tag_rd),
        .match_raw  (match_raw)
    );

    cam_prio_sel #(
        .ENTRIES(ENTRIES)
    ) u_prio (
        .match_raw (match_raw),
        .word_sel  (word_sel),
        .hit_kind  (hit_kind)
    );

    cam_data_ram #(
        .ENTRIES(ENTRIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .word_sel (word_sel),
        .rd_data  (val_rd),
        .sel_data (val_sel)
    );

    always_comb begin
        o_d         = o_q;
        o_d.rd_vld  = rd_en;
        o_d.res_vld = search_en;
        if (rd_en) begin
            o_d.rd_key  = tag_rd;
            o_d.rd_data = val_rd;
        end
        if (search_en) begin
            o_d.match  = match_raw;
            o_d.miss   = (hit_kind == HIT_NONE);
            o_d.multi  = (hit_kind == HIT_MULTI);
            o_d.lookup = val_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rd_valid     = o_q.rd_vld;
    assign rd_key       = o_q.rd_key;
    assign rd_data      = o_q.rd_data;
    assign result_valid = o_q.res_vld;
    assign match        = o_q.match;
    assign miss         = o_q.miss;
    assign multi_hit    = o_q.multi;
    assign lookup_data  = o_q.lookup;

endmodule

// File: rtl/cam_lookup_chk.sv
module cam_lookup_chk #(
    parameter int ENTRIES = 4,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic               search_en,
    input logic               rd_valid,
    input logic               result_valid,
    input logic [ENTRIES-1:0] match,
    input logic               miss,
    input logic               multi_hit,
    input logic [DATA_W-1:0]  lookup_data
);

    assert_read_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_result_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        search_en |=> result_valid);

    assert_no_spurious_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !search_en |=> !result_valid);

    assert_miss_iff_none_R4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (miss == (match == '0)));

    assert_miss_zero_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && miss) |-> (lookup_data == '0));

    assert_multi_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (multi_hit == ($countones(match) > 1)));

    assert_hold_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(match) && $stable(miss) && $stable(lookup_data)));

endmodule

bind cam_lookup cam_lookup_chk #(
    .ENTRIES(ENTRIES), .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .search_en    (search_en),
    .rd_valid     (rd_valid),
    .result_valid (result_valid),
    .match        (match),
    .miss         (miss),
    .multi_hit    (multi_hit),
    .lookup_data  (lookup_data)
);

// File: tb/cam_lookup_tb.sv
module cam_lookup_tb;

    localparam int ENTRIES = 4;
    localparam int KEY_W   = 4;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [KEY_W-1:0]   wr_key = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic               rd_en = 1'b0;
    logic               search_en = 1'b0;
    logic [KEY_W-1:0]   search_key = '0;
    logic               rd_valid;
    logic [KEY_W-1:0]   rd_key;
    logic [DATA_W-1:0]  rd_data;
    logic               result_valid;
    logic [ENTRIES-1:0] match;
    logic               miss;
    logic               multi_hit;
    logic [DATA_W-1:0]  lookup_data;

    always #5 clk = ~clk;

    cam_lookup #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_key(wr_key),
        .wr_data(wr_data), .rd_en(rd_en), .search_en(search_en),
        .search_key(search_key), .rd_valid(rd_valid), .rd_key(rd_key),
        .rd_data(rd_data), .result_valid(result_valid), .match(match),
        .miss(miss), .multi_hit(multi_hit), .lookup_data(lookup_data)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference table
    logic [KEY_W-1:0]  m_key [ENTRIES];
    logic [DATA_W-1:0] m_dat [ENTRIES];
    logic              m_vld [ENTRIES];

    // Scoreboard queues
    logic [ENTRIES-1:0] q_match [$];
    logic               q_miss  [$];
    logic               q_multi [$];
    logic [DATA_W-1:0]  q_look  [$];
    string              q_sreq  [$];
    logic [KEY_W-1:0]   q_rkey  [$];
    logic [DATA_W-1:0]  q_rdat  [$];
    string              q_rreq  [$];

    logic [ENTRIES-1:0] last_match = '0;
    logic               last_miss  = 1'b0;
    logic [DATA_W-1:0]  last_look  = '0;
    bit                 mon_on     = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; expectations use the table before the write.
    task automatic step(input bit we, input logic [ADDR_W-1:0] a,
                        input logic [KEY_W-1:0] k, input logic [DATA_W-1:0] d,
                        input bit re, input bit se, input logic [KEY_W-1:0] sk,
                        input string req);
        logic [ENTRIES-1:0] em;
        logic [DATA_W-1:0]  ed;
        int                 hits;
        @(negedge clk);
        wr_en = we; addr = a; wr_key = k; wr_data = d;
        rd_en = re; search_en = se; search_key = sk;
        if (se) begin
            em = '0; ed = '0; hits = 0;
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (m_vld[i] && m_key[i] == sk) begin
                    em[i] = 1'b1; ed = m_dat[i]; hits++;
                end
            end
            q_match.push_back(em); q_miss.push_back(hits == 0);
            q_multi.push_back(hits > 1); q_look.push_back(ed);
            q_sreq.push_back(req);
        end
        if (re) begin
            q_rkey.push_back(m_key[a]); q_rdat.push_back(m_dat[a]);
            q_rreq.push_back(req);
        end
        if (we) begin
            m_key[a] = k; m_dat[a] = d; m_vld[a] = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, "idle");
    endtask

    // Monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (result_valid) begin
                if (q_match.size() == 0) begin
                    check(1'b0, "R3", "unexpected result_valid", 32'(result_valid), 32'd0);
                end else begin
                    string r;
                    r = q_sreq.pop_front();
                    check(match == q_match[0], r, "match", 32'(match), 32'(q_match[0]));
                    check(miss == q_miss[0], r, "miss", 32'(miss), 32'(q_miss[0]));
                    check(multi_hit == q_multi[0], r, "multi_hit", 32'(multi_hit), 32'(q_multi[0]));
                    check(lookup_data == q_look[0], r, "lookup_data", 32'(lookup_data), 32'(q_look[0]));
                    void'(q_match.pop_front()); void'(q_miss.pop_front());
                    void'(q_multi.pop_front()); void'(q_look.pop_front());
                end
                last_match = match; last_miss = miss; last_look = lookup_data;
            end else begin
                check(match == last_match && miss == last_miss && lookup_data == last_look,
                      "R10", "held result", {match, lookup_data}, {last_match, last_look});
            end
            if (rd_valid) begin
                if (q_rkey.size() == 0) begin
                    check(1'b0, "R2", "unexpected rd_valid", 32'(rd_valid), 32'd0);
                end else begin
                    string r;
                    r = q_rreq.pop_front();
                    check(rd_key == q_rkey[0], r, "rd_key", 32'(rd_key), 32'(q_rkey[0]));
                    check(rd_data == q_rdat[0], r, "rd_data", 32'(rd_data), 32'(q_rdat[0]));
                    void'(q_rkey.pop_front()); void'(q_rdat.pop_front());
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_key[i] = '0; m_dat[i] = '0; m_vld[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({rd_valid, rd_key, rd_data, result_valid, match, miss, multi_hit, lookup_data} == '0,
              "R1", "reset outputs", {match, lookup_data}, 32'd0);
        mon_on = 1'b1;

        // R1 / R8: empty table, key equal to the zero reset contents
        step(1'b0, 2'd0, 4'h0, 8'h00, 1'b0, 1'b1, 4'h0, "R8");
        // R2: load four entries
        step(1'b1, 2'd0, 4'h3, 8'hA1, 1'b0, 1'b0, 4'h0, "R2");
        step(1'b1, 2'd1, 4'h5, 8'hB2, 1'b0, 1'b0, 4'h0, "R2");
        step(1'b1, 2'd2, 4'h9, 8'hC3, 1'b0, 1'b0, 4'h0, "R2");
        step(1'b1, 2'd3, 4'hF, 8'hD4, 1'b0, 1'b0, 4'h0, "R2");
        for (int i = 0; i < ENTRIES; i++)
            step(1'b0, ADDR_W'(i), 4'h0, 8'h00, 1'b1, 1'b0, 4'h0, "R2");
        // R3 / R5: single hits at various indices, back to back
        step(1'b0, 2'd0, 4'h0, 8'h00, 1'b0, 1'b1, 4'h5, "R5");
        step(1'b0, 2'd0, 4'h0, 8'h00, 1'b0, 1'b1, 4'hF, "R5");
        step(1'b0, 2'd0, 4'h0, 8'h00, 1'b0, 1'b1, 4'h3, "R3");
        idle(2);
        // R4: absent keys
        step(1'b0, 2'd0, 4'h0, 8'h00, 1'b0, 1'b1, 4'h7, "R4");
        step(1'b0, 2'd0, 4'h0, 8'h00, 1'b0, 1'b1, 4'h0, "R4");
        idle(3);
        // R7: overwrite entry 2 with a duplicate of entry 1 while searching its old tag
        step(1'b1, 2'd2, 4'h5, 8'h77, 1'b0, 1'b1, 4'h9, "R7");
        // R6: duplicate tag, lowest index wins
        step(1'b0, 2'd0, 4'h0, 8'h00, 1'b0, 1'b1, 4'h5, "R6");
        step(1'b0, 2'd0, 4'h0, 8'h00, 1'b0, 1'b1, 4'h9, "R4");
        // R6: three-way duplicate
        step(1'b1, 2'd0, 4'h5, 8'h11, 1'b0, 1'b0, 4'h0, "R6");
        step(1'b0, 2'd0, 4'h0, 8'h00, 1'b0, 1'b1, 4'h5, "R6");
        idle(2);
        // R9: read and write the same address in one cycle
        step(1'b1, 2'd3, 4'hE, 8'h42, 1'b1, 1'b0, 4'h0, "R9");
        step(1'b0, 2'd3, 4'h0, 8'h00, 1'b1, 1'b1, 4'hE, "R9");
        idle(4);
        mon_on = 1'b0;
        check(q_match.size() == 0, "R3", "pending searches", 32'(q_match.size()), 32'd0);
        check(q_rkey.size() == 0, "R2", "pending reads", 32'(q_rkey.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R3 watchdog: actual %0d expected %0d", 20000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule